// File: doc/BRIEF.md
# OTP Packet Directory Builder

After reset this engine walks a packetized one-time-programmable word array and builds an index of its packets. Every packet begins with a one-word header whose bits 15:8 hold the payload length S in words, followed by S+1 further words. The next header therefore sits S+2 words after the current one. The engine reads headers one at a time through a simple request/acknowledge port. It numbers the packets it finds 0, 1, 2, ... in memory order and stores each packet's starting word offset in a small table.

A consumer can then ask for a packet by its ordinal and get back its start offset. This works even when packet lengths differ between memory images. The lookup key is given as a byte offset on a 4-byte stride, so the engine divides it by 4 to get the packet ordinal. The engine also reports how many packets it found, the number of bytes they occupy, a done flag, and an overflow flag that is set when the table ran out of room.

Top module: `otp_pkt_dir`

## Requirements
- R1: While reset is held, and until the scan starts: `scan_done`, `scan_ovf` and `mem_req` are 0, `pkt_count` is 0, `bytes_used` is 0 and `lkp_hit` is 0.
- R2: The first header read is at word 0. The payload size S is taken from `mem_rdata[15:8]`; every other header bit is ignored.
- R3: After a packet of size S at word W, the next header read is at word W+S+2.
- R4: Recorded packets get consecutive ordinals from 0 in memory order. A lookup of ordinal k returns the word offset of the k-th packet's header on `lkp_off`.
- R5: `bytes_used` grows by 4*(S+1) for each recorded packet.
- R6: A header with S=0 ends the scan. It is not counted, and `scan_ovf` stays 0.
- R7: When `bytes_used` reaches or passes CAP_BYTES (default 11264), the scan ends and no further read is issued.
- R8: If a non-zero header arrives while DIR_DEPTH packets are already recorded, the scan ends with `scan_ovf`=1 and that packet is not recorded. A zero header in the same situation ends the scan cleanly.
- R9: The lookup ordinal is `lkp_key` divided by 4; `lkp_key[1:0]` has no effect.
- R10: `lkp_hit` is 1 only when `scan_done`=1 and the ordinal is below `pkt_count`; otherwise it is 0.
- R11: `mem_req` is a one-cycle pulse, and no new request is issued until `mem_ack` has returned the previous word.
- R12: Once `scan_done` is set it stays set, and no read is issued until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the scan starts after release |
| mem_req | output | 1 | One-cycle read request to the OTP word array |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word, sampled when `mem_ack` is 1 |
| lkp_key | input | KEY_W | Lookup key as a byte offset (ordinal times 4) |
| lkp_hit | output | 1 | Lookup result is valid |
| lkp_off | output | ADDR_W | Start word offset of the looked-up packet (0 on miss) |
| scan_done | output | 1 | Scan finished |
| scan_ovf | output | 1 | Scan stopped because the table was full |
| pkt_count | output | CNT_W | Number of recorded packets |
| bytes_used | output | BYTE_W | Total bytes occupied by the recorded packets |

## Verification
The capacity stop and the full-table condition can land on the same packet. This happens when the sixteenth recorded packet brings the byte total to exactly the capacity. In that case the capacity stop must win: the scan ends with no further header read and without raising the overflow flag. An image of sixteen packets of size 175 provokes this case. It is judged by the number of reads the memory model served, the overflow flag, and the count and byte totals. Neighbouring images cover the two cases on either side: one where the table fills and a further non-zero header arrives, and one where the table fills and the next header is a terminator.

// File: rtl/otp_pkt_dir.sv
module otp_pkt_dir #(
  parameter int ADDR_W    = 16,
  parameter int KEY_W     = 16,
  parameter int DIR_DEPTH = 16,
  parameter int CAP_BYTES = 11264,
  localparam int IDW      = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1,
  localparam int CNT_W    = $clog2(DIR_DEPTH + 1),
  localparam int BYTE_W   = $clog2(CAP_BYTES + 1025)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic [KEY_W-1:0]  lkp_key,
  output logic              lkp_hit,
  output logic [ADDR_W-1:0] lkp_off,
  output logic              scan_done,
  output logic              scan_ovf,
  output logic [CNT_W-1:0]  pkt_count,
  output logic [BYTE_W-1:0] bytes_used
);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_DECODE, S_DONE} st_t;

  st_t               state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [7:0]        sz_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] bytes_q;
  logic              ovf_q;
  logic [ADDR_W-1:0] dir_q [DIR_DEPTH];

  logic [BYTE_W-1:0] nxt_bytes;
  logic              full, rec;
  logic [KEY_W-3:0]  lkp_id;
  logic              unused_bits;

  assign nxt_bytes = bytes_q + BYTE_W'({sz_q, 2'b00}) + BYTE_W'(4);
  assign full      = (cnt_q == CNT_W'(DIR_DEPTH));
  assign rec       = (state_q == S_DECODE) && (sz_q != 8'd0) && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      sz_q    <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE:  state_q <= S_ISSUE;
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (mem_ack) begin
          sz_q    <= mem_rdata[15:8];
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          if (sz_q == 8'd0) begin
            state_q <= S_DONE;
          end else if (full) begin
            ovf_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            bytes_q <= nxt_bytes;
            cur_q   <= cur_q + ADDR_W'(sz_q) + ADDR_W'(2);
            state_q <= (nxt_bytes >= BYTE_W'(CAP_BYTES)) ? S_DONE : S_ISSUE;
          end
        end
        default: state_q <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rec) dir_q[cnt_q[IDW-1:0]] <= cur_q;
  end

  assign mem_req    = (state_q == S_ISSUE);
  assign mem_addr   = cur_q;
  assign scan_done  = (state_q == S_DONE);
  assign scan_ovf   = ovf_q;
  assign pkt_count  = cnt_q;
  assign bytes_used = bytes_q;

  assign lkp_id  = lkp_key[KEY_W-1:2];
  assign lkp_hit = scan_done && (32'(lkp_id) < 32'(cnt_q));
  assign lkp_off = lkp_hit ? dir_q[lkp_id[IDW-1:0]] : '0;

  assign unused_bits = ^{lkp_key[1:0], mem_rdata[31:16], mem_rdata[7:0]};

  // R10
  hit_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> scan_done);

  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_ovf |-> (pkt_count == CNT_W'(DIR_DEPTH)));

  // R11
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R12
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (scan_done && !mem_req));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count != $past(pkt_count)) |-> (pkt_count == $past(pkt_count) + CNT_W'(1)));

  // R7
  cap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_used >= BYTE_W'(CAP_BYTES)) |-> !mem_req);

endmodule

// File: tb/otp_pkt_dir_tb.sv
`timescale 1ns/1ps
module otp_pkt_dir_tb;
  localparam int ADDR_W = 16, KEY_W = 16, DEPTH = 16, CAP = 11264;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              mem_req, mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata = '0;
  logic [KEY_W-1:0]  lkp_key = '0;
  logic              lkp_hit, scan_done, scan_ovf;
  logic [ADDR_W-1:0] lkp_off;
  logic [4:0]        pkt_count;
  logic [13:0]       bytes_used;

  otp_pkt_dir #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .DIR_DEPTH(DEPTH), .CAP_BYTES(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .lkp_key(lkp_key),
    .lkp_hit(lkp_hit), .lkp_off(lkp_off), .scan_done(scan_done),
    .scan_ovf(scan_ovf), .pkt_count(pkt_count), .bytes_used(bytes_used));

  logic [31:0] img [0:4095];
  int rd_cnt, first_addr;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int m_off [0:DEPTH-1];
  int m_cnt, m_bytes, m_reads;
  bit m_ovf;

  typedef struct {
    bit          is_stat;
    bit          hit;
    int          off;
    int          cnt;
    int          bytes;
    bit          done;
    bit          ovf;
    string       tag;
  } item_t;
  item_t sbq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory responder: one-cycle ack after a 1..3 cycle latency
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      int a;
      a = int'(mem_addr);
      if (rd_cnt == 0) first_addr = a;
      rd_cnt++;
      repeat (1 + rd_cnt % 3) @(negedge clk);
      mem_rdata = img[a[11:0]];
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = 32'hDEAD_BEEF;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.is_stat) begin
        check(scan_done === it.done, {it.tag, " done"}, int'(scan_done), int'(it.done));
        check(scan_ovf === it.ovf, {it.tag, " ovf"}, int'(scan_ovf), int'(it.ovf));
        check(int'(pkt_count) == it.cnt, {it.tag, " count"}, int'(pkt_count), it.cnt);
        check(int'(bytes_used) == it.bytes, {it.tag, " bytes"}, int'(bytes_used), it.bytes);
      end else begin
        check(lkp_hit === it.hit, {it.tag, " hit"}, int'(lkp_hit), int'(it.hit));
        if (it.hit)
          check(int'(lkp_off) == it.off, {it.tag, " offset"}, int'(lkp_off), it.off);
      end
    end
  end

  task automatic model_walk();
    int cur, s;
    cur = 0; m_cnt = 0; m_bytes = 0; m_reads = 0; m_ovf = 0;
    forever begin
      if (m_bytes >= CAP) break;
      m_reads++;
      s = int'(img[cur][15:8]);
      if (s == 0) break;
      if (m_cnt == DEPTH) begin m_ovf = 1; break; end
      m_off[m_cnt] = cur;
      m_cnt++;
      m_bytes += 4 * (s + 1);
      cur += s + 2;
    end
  endtask

  task automatic probe(input int key, input bit after_done, input string tag);
    item_t it;
    int id;
    @(posedge clk); #1;
    lkp_key = KEY_W'(key);
    id = key / 4;
    it.is_stat = 0;
    it.hit = after_done && (id < m_cnt);
    it.off = it.hit ? m_off[id] : 0;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic stat(input bit done, input bit ovf, input int cnt, input int bytes, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_stat = 1; it.done = done; it.ovf = ovf; it.cnt = cnt; it.bytes = bytes; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic clr_img();
    for (int i = 0; i < 4096; i++) img[i] = 32'h3C3C_003C;
  endtask

  task automatic put_pkts(inout int w, input int n, input int s);
    for (int k = 0; k < n; k++) begin
      img[w] = 32'h9A00_0055 | (32'(k) << 24) | (32'(s) << 8);
      w += s + 2;
    end
  endtask

  task automatic run_image(input string name);
    int guard;
    model_walk();
    rst_n = 1'b0;
    rd_cnt = 0; first_addr = -1;
    repeat (3) @(posedge clk);
    stat(0, 0, 0, 0, {"R1 reset ", name});
    check(mem_req === 1'b0, {"R1 req in reset ", name}, int'(mem_req), 0);
    probe(0, 0, {"R1 lookup in reset ", name});
    @(posedge clk); #1 rst_n = 1'b1;
    probe(0, 0, {"R10 lookup before done ", name});
    guard = 0;
    while (!scan_done && guard < 60000) begin @(posedge clk); guard++; end
    repeat (3) @(posedge clk);
    stat(1, m_ovf, m_cnt, m_bytes, {"R5 R6 R7 R8 status ", name});
    @(negedge clk);
    check(rd_cnt == m_reads, {"R7 R12 read count ", name}, rd_cnt, m_reads);
    check(first_addr == 0, {"R2 first address ", name}, first_addr, 0);
    for (int k = 0; k <= m_cnt && k <= DEPTH; k++)
      probe(4 * k, 1, {"R4 R10 lookup ", name});
    if (m_cnt > 1) probe(4 * 1 + 3, 1, {"R9 low bits ", name});
    probe(16'hFFFC, 1, {"R10 far key ", name});
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int w;
    // A: three packets, junk header bits, terminator with junk
    clr_img(); w = 0;
    put_pkts(w, 1, 3); put_pkts(w, 1, 1); put_pkts(w, 1, 5);
    img[w] = 32'hA5A5_00C3;
    run_image("A");
    check(m_off[2] == 8 && m_bytes == 48, "R3 R5 model A", m_off[2], 8);
    // F: terminator at word 0
    clr_img(); img[0] = 32'hFFFF_00FF;
    run_image("F");
    // B: seventeen packets -> overflow
    clr_img(); w = 0; put_pkts(w, 17, 1); img[w] = 32'h0;
    run_image("B ovf");
    check(m_ovf == 1, "R8 model B", int'(m_ovf), 1);
    // C: full table then terminator
    clr_img(); w = 0; put_pkts(w, 16, 2); img[w] = 32'h0000_0011;
    run_image("C full+end");
    // D: capacity reached by eleven large packets
    clr_img(); w = 0; put_pkts(w, 14, 255);
    run_image("D cap");
    // E: capacity and full table on the same packet
    clr_img(); w = 0; put_pkts(w, 18, 175);
    run_image("E cap+full");
    check(m_ovf == 0 && m_cnt == 16, "R7 R8 model E", m_cnt, 16);
    repeat (5) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule